// File: doc/BRIEF.md
# Interrupt Redirection Table Controller

This block routes 24 interrupt input pins to processor targets as messages. Each pin owns a 64-bit redirection entry. The entry sets the vector, the delivery mode, how the destination is read (physical or logical), the destination itself, the pin polarity, edge or level triggering and a mask bit. Software reaches every entry indirectly. It first writes a register index into an index register. It then reads or writes the chosen 32-bit half through a data window. Index 0x10 + 2n selects bits 31:0 of entry n, and index 0x10 + 2n + 1 selects bits 63:32.

Each input is registered once and then inverted when its polarity bit is set. An edge-mode pin latches a pending flag on an inactive-to-active transition. A level-mode pin requests service for as long as it is active and its remote acknowledge flag is clear. Among the unmasked requests, the lowest-numbered pin is captured into a single output message slot. The slot is offered on a valid/ready port. Only one message is outstanding at a time. The message stays valid, with all fields frozen, until the ready handshake. Back-pressure therefore holds the slot and delays every later message without losing any. While a pin's message is waiting, that pin's delivery-status bit reads 1. When a level-mode message is accepted, the pin's remote acknowledge bit is set. An end-of-interrupt strobe whose vector matches the entry clears it.

Top module: `irq_router`

## Requirements
- R1: After reset, every entry reads 0x0001_0000 at its low index and 0x0000_0000 at its high index, so the entry is masked with all other fields zero, and msg_valid is 0.
- R2: Index 0x10+2n accesses entry n bits 31:0 and 0x10+2n+1 accesses bits 63:32. The writable low fields are vector 7:0, delivery mode 10:8, destination mode 11, polarity 13, trigger 15 and mask 16. The writable high field is destination 63:56 (window bits 31:24). All other bits read 0. Indices below 0x10 or at 0x40 and above read 0, and writes to them change no entry.
- R3: Delivery status (bit 12) and remote acknowledge (bit 14) are read-only. Window writes to those bit positions are ignored.
- R4: With trigger 0 (edge), each inactive-to-active transition of an unmasked pin produces exactly one message. Holding the input active produces no further message.
- R5: With polarity 1, a low input level is the active level. The falling edge of the input triggers a message and the rising edge does not.
- R6: While mask (bit 16) is 1, the pin issues no message. Edges that arrive while the pin is masked are discarded. A level-mode pin that is active when it is unmasked is issued.
- R7: A message carries the entry's vector on msg_vector, bits 10:8 on msg_dmode, bit 11 on msg_logical, bits 63:56 on msg_dest and the pin number on msg_pin, all as they were when the message was captured.
- R8: Once msg_valid is 1, it stays 1 with every message field unchanged until a cycle with msg_ready 1. Only one message is outstanding, and a pin that requests meanwhile is issued after the acceptance.
- R9: Delivery status (bit 12) of the issuing pin reads 1 from capture until the cycle after acceptance, and reads 0 afterwards.
- R10: When a level-mode message is accepted, remote acknowledge (bit 14) is set and the pin issues nothing more. An eoi_valid strobe with a non-matching eoi_vector leaves the bit set. A matching one clears it, and the pin issues again if it is still active.
- R11: When several pins are pending together, the lowest-numbered pin is issued first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 24 | Raw interrupt input pins |
| idx_wr | input | 1 | Write strobe of the index register |
| idx_wdata | input | 8 | Register index to select |
| win_wr | input | 1 | Write strobe of the data window |
| win_wdata | input | 32 | Data written to the selected register |
| win_rdata | output | 32 | Contents of the selected register |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector being acknowledged |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message accepted when high with msg_valid |
| msg_vector | output | 8 | Vector of the message |
| msg_dmode | output | 3 | Delivery mode of the message |
| msg_logical | output | 1 | 1 when the destination is logical |
| msg_dest | output | 8 | Destination field |
| msg_pin | output | 5 | Pin that raised the message |

## Verification
The assertions assume that msg_ready is only treated as an acceptance while msg_valid is high. They also assume that a software write to a pin's trigger mode never races with the acceptance of that pin's own message. Under these conditions, remote acknowledge can rise only after a handshake and can fall only after an end-of-interrupt strobe. The stimulus keeps each pin's entry fixed while its message is outstanding. It drives the inputs only on falling clock edges. It sets an active-low pin to its idle level while the pin is still masked, so that a polarity change cannot produce a spurious edge.

// File: rtl/irq_rt_pkg.sv
package irq_rt_pkg;
  // Writable part of one redirection entry; status bits live elsewhere.
  typedef struct packed {
    logic [7:0] dest;
    logic       mask;
    logic       trig;
    logic       pol;
    logic       dlog;
    logic [2:0] dmode;
    logic [7:0] vec;
  } rte_t;

  localparam rte_t RTE_RESET = '{dest: 8'd0, mask: 1'b1, trig: 1'b0, pol: 1'b0,
                                 dlog: 1'b0, dmode: 3'd0, vec: 8'd0};
endpackage

// File: rtl/irq_rt_regs.sv
module irq_rt_regs
  import irq_rt_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int IDX_W    = 8,
  parameter int BASE_IDX = 16,
  localparam int PIN_W   = $clog2(NUM_PINS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        idx_wr,
  input  logic [IDX_W-1:0]            idx_wdata,
  input  logic                        win_wr,
  input  logic [31:0]                 win_wdata,
  output logic [31:0]                 win_rdata,
  input  logic                        issue_fire,
  input  logic [PIN_W-1:0]            issue_pin,
  input  logic                        accept_fire,
  input  logic [PIN_W-1:0]            accept_pin,
  input  logic                        accept_level,
  input  logic                        eoi_valid,
  input  logic [7:0]                  eoi_vector,
  output rte_t [NUM_PINS-1:0]         entries,
  output logic [NUM_PINS-1:0]         dstat,
  output logic [NUM_PINS-1:0]         rirr
);
  localparam logic [IDX_W-1:0] IDX_LO = IDX_W'(BASE_IDX);
  localparam logic [IDX_W-1:0] IDX_HI = IDX_W'(BASE_IDX + 2 * NUM_PINS);

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] off;
  logic             hit;
  logic             hi_half;
  logic [PIN_W-1:0] sel_pin;

  always_ff @(posedge clk) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_wr) idx_q <= idx_wdata;
  end

  assign off     = idx_q - IDX_LO;
  assign hit     = (idx_q >= IDX_LO) && (idx_q < IDX_HI);
  assign hi_half = off[0];
  assign sel_pin = off[PIN_W:1];

  logic unused_bits;
  assign unused_bits = ^{win_wdata[23:17], win_wdata[14], win_wdata[12], off[IDX_W-1:PIN_W+1]};

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_ent
    logic wr_me;
    assign wr_me = win_wr && hit && (sel_pin == PIN_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        entries[i] <= RTE_RESET;
      end else if (wr_me) begin
        if (hi_half) begin
          entries[i].dest <= win_wdata[31:24];
        end else begin
          entries[i].vec   <= win_wdata[7:0];
          entries[i].dmode <= win_wdata[10:8];
          entries[i].dlog  <= win_wdata[11];
          entries[i].pol   <= win_wdata[13];
          entries[i].trig  <= win_wdata[15];
          entries[i].mask  <= win_wdata[16];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n)                                     dstat[i] <= 1'b0;
      else if (issue_fire && issue_pin == PIN_W'(i))   dstat[i] <= 1'b1;
      else if (accept_fire && accept_pin == PIN_W'(i)) dstat[i] <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)
        rirr[i] <= 1'b0;
      else if (accept_fire && accept_level && accept_pin == PIN_W'(i))
        rirr[i] <= 1'b1;
      else if (eoi_valid && eoi_vector == entries[i].vec)
        rirr[i] <= 1'b0;
    end
  end

  always_comb begin
    win_rdata = '0;
    if (hit) begin
      if (hi_half) begin
        win_rdata = {entries[sel_pin].dest, 24'd0};
      end else begin
        win_rdata = {15'd0, entries[sel_pin].mask, entries[sel_pin].trig, rirr[sel_pin],
                     entries[sel_pin].pol, dstat[sel_pin], entries[sel_pin].dlog,
                     entries[sel_pin].dmode, entries[sel_pin].vec};
      end
    end
  end
endmodule

// File: rtl/irq_rt_cond.sv
module irq_rt_cond #(
  parameter int NUM_PINS = 24,
  localparam int PIN_W   = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] irq_in,
  input  logic [NUM_PINS-1:0] pol_v,
  input  logic [NUM_PINS-1:0] trig_v,
  input  logic [NUM_PINS-1:0] mask_v,
  input  logic [NUM_PINS-1:0] dstat,
  input  logic [NUM_PINS-1:0] rirr,
  input  logic                issue_fire,
  input  logic [PIN_W-1:0]    issue_pin,
  output logic [NUM_PINS-1:0] req
);
  logic [NUM_PINS-1:0] in_q;

  always_ff @(posedge clk) begin
    if (!rst_n) in_q <= '0;
    else        in_q <= irq_in;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic act, act_q, pend;
    assign act = in_q[i] ^ pol_v[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        act_q <= 1'b0;
        pend  <= 1'b0;
      end else begin
        act_q <= act;
        if (trig_v[i] || (issue_fire && issue_pin == PIN_W'(i)))
          pend <= 1'b0;
        else if (!mask_v[i] && act && !act_q)
          pend <= 1'b1;
      end
    end

    assign req[i] = !mask_v[i] && !dstat[i] && (trig_v[i] ? (act && !rirr[i]) : pend);
  end
endmodule

// File: rtl/irq_rt_arb.sv
module irq_rt_arb
  import irq_rt_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int PIN_W   = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] req,
  input  rte_t [NUM_PINS-1:0] entries,
  input  logic                msg_ready,
  output logic                msg_valid,
  output logic [7:0]          msg_vector,
  output logic [2:0]          msg_dmode,
  output logic                msg_logical,
  output logic [7:0]          msg_dest,
  output logic [PIN_W-1:0]    msg_pin,
  output logic                issue_fire,
  output logic [PIN_W-1:0]    issue_pin,
  output logic                accept_fire,
  output logic                accept_level
);
  logic             busy_q;
  rte_t             slot_q;
  logic [PIN_W-1:0] pin_q;
  logic [PIN_W-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (req[i]) pick = PIN_W'(i);
    end
  end

  assign issue_fire  = !busy_q && (|req);
  assign issue_pin   = pick;
  assign accept_fire = busy_q && msg_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      slot_q <= '0;
      pin_q  <= '0;
    end else if (issue_fire) begin
      busy_q <= 1'b1;
      slot_q <= entries[pick];
      pin_q  <= pick;
    end else if (accept_fire) begin
      busy_q <= 1'b0;
    end
  end

  logic unused_slot;
  assign unused_slot = slot_q.pol ^ slot_q.mask;

  assign msg_valid    = busy_q;
  assign msg_vector   = slot_q.vec;
  assign msg_dmode    = slot_q.dmode;
  assign msg_logical  = slot_q.dlog;
  assign msg_dest     = slot_q.dest;
  assign msg_pin      = pin_q;
  assign accept_level = slot_q.trig;
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_rt_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int IDX_W    = 8,
  parameter int BASE_IDX = 16,
  localparam int PIN_W   = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] irq_in,
  input  logic                idx_wr,
  input  logic [IDX_W-1:0]    idx_wdata,
  input  logic                win_wr,
  input  logic [31:0]         win_wdata,
  output logic [31:0]         win_rdata,
  input  logic                eoi_valid,
  input  logic [7:0]          eoi_vector,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [7:0]          msg_vector,
  output logic [2:0]          msg_dmode,
  output logic                msg_logical,
  output logic [7:0]          msg_dest,
  output logic [PIN_W-1:0]    msg_pin
);
  rte_t [NUM_PINS-1:0] entries;
  logic [NUM_PINS-1:0] dstat, rirr, req, pol_v, trig_v, mask_v;
  logic                issue_fire, accept_fire, accept_level;
  logic [PIN_W-1:0]    issue_pin;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_fld
    assign pol_v[i]  = entries[i].pol;
    assign trig_v[i] = entries[i].trig;
    assign mask_v[i] = entries[i].mask;
  end

  irq_rt_regs #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W), .BASE_IDX(BASE_IDX)) u_regs (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .idx_wdata(idx_wdata),
    .win_wr(win_wr), .win_wdata(win_wdata), .win_rdata(win_rdata),
    .issue_fire(issue_fire), .issue_pin(issue_pin),
    .accept_fire(accept_fire), .accept_pin(msg_pin), .accept_level(accept_level),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .entries(entries), .dstat(dstat), .rirr(rirr)
  );

  irq_rt_cond #(.NUM_PINS(NUM_PINS)) u_cond (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .pol_v(pol_v), .trig_v(trig_v),
    .mask_v(mask_v), .dstat(dstat), .rirr(rirr),
    .issue_fire(issue_fire), .issue_pin(issue_pin), .req(req)
  );

  irq_rt_arb #(.NUM_PINS(NUM_PINS)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req), .entries(entries), .msg_ready(msg_ready),
    .msg_valid(msg_valid), .msg_vector(msg_vector), .msg_dmode(msg_dmode),
    .msg_logical(msg_logical), .msg_dest(msg_dest), .msg_pin(msg_pin),
    .issue_fire(issue_fire), .issue_pin(issue_pin),
    .accept_fire(accept_fire), .accept_level(accept_level)
  );
endmodule

// File: rtl/irq_rt_chk.sv
module irq_rt_chk
  import irq_rt_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int PIN_W   = $clog2(NUM_PINS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                msg_valid,
  input logic                msg_ready,
  input logic [7:0]          msg_vector,
  input logic [7:0]          msg_dest,
  input logic [PIN_W-1:0]    msg_pin,
  input logic [NUM_PINS-1:0] dstat,
  input logic [NUM_PINS-1:0] rirr,
  input logic [NUM_PINS-1:0] req,
  input logic                issue_fire,
  input logic [PIN_W-1:0]    issue_pin,
  input logic                eoi_valid,
  input rte_t [NUM_PINS-1:0] entries
);
  AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector) && $stable(msg_dest) && $stable(msg_pin))); // R8

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dstat) && (msg_valid == (dstat != '0))); // R9

  AST_NO_MASKED_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |-> (!entries[issue_pin].mask && req[issue_pin])); // R6

  AST_ACK_SET_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ((rirr & ~$past(rirr)) != '0) |-> $past(msg_valid && msg_ready)); // R10

  AST_ACK_CLEAR_ON_EOI: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(rirr) & ~rirr) != '0) |-> $past(eoi_valid)); // R10
endmodule

bind irq_router irq_rt_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_vector(msg_vector), .msg_dest(msg_dest), .msg_pin(msg_pin),
  .dstat(dstat), .rirr(rirr), .req(req), .issue_fire(issue_fire),
  .issue_pin(issue_pin), .eoi_valid(eoi_valid), .entries(entries)
);

// File: tb/irq_router_tb.sv
`timescale 1ns/100ps
module irq_router_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] irq_in = '0;
  logic        idx_wr = 1'b0, win_wr = 1'b0, eoi_valid = 1'b0, msg_ready = 1'b0;
  logic [7:0]  idx_wdata = '0, eoi_vector = '0;
  logic [31:0] win_wdata = '0;
  logic [31:0] win_rdata;
  logic        msg_valid, msg_logical;
  logic [7:0]  msg_vector, msg_dest;
  logic [2:0]  msg_dmode;
  logic [4:0]  msg_pin;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_router u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .idx_wr(idx_wr), .idx_wdata(idx_wdata),
    .win_wr(win_wr), .win_wdata(win_wdata), .win_rdata(win_rdata),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_vector(msg_vector), .msg_dmode(msg_dmode),
    .msg_logical(msg_logical), .msg_dest(msg_dest), .msg_pin(msg_pin)
  );

  typedef struct packed {
    logic [4:0] pin;
    logic [7:0] vec;
    logic [2:0] dm;
    logic       lg;
    logic [7:0] dst;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t TBL [NV] = '{
    '{5'd0,  8'h31, 3'b000, 1'b0, 8'h01},
    '{5'd23, 8'hE7, 3'b001, 1'b1, 8'h80},
    '{5'd1,  8'h40, 3'b010, 1'b0, 8'h0F},
    '{5'd12, 8'h9C, 3'b100, 1'b1, 8'h3C},
    '{5'd17, 8'h21, 3'b101, 1'b0, 8'h07},
    '{5'd6,  8'hF0, 3'b111, 1'b1, 8'hFF}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] idx, input logic [31:0] d);
    @(negedge clk); idx_wr = 1'b1; idx_wdata = idx;
    @(negedge clk); idx_wr = 1'b0; win_wr = 1'b1; win_wdata = d;
    @(negedge clk); win_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] idx, output logic [31:0] d);
    @(negedge clk); idx_wr = 1'b1; idx_wdata = idx;
    @(negedge clk); idx_wr = 1'b0;
    #1 d = win_rdata;
  endtask

  task automatic wait_msg(input int lim, output bit got);
    got = 1'b0;
    for (int k = 0; k < lim && !got; k++) begin
      @(negedge clk);
      #1 if (msg_valid) got = 1'b1;
    end
  endtask

  task automatic accept();
    @(negedge clk); msg_ready = 1'b1;
    @(negedge clk); msg_ready = 1'b0;
  endtask

  task automatic quiet(input string tag, input int n);
    bit seen = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      #1 if (msg_valid) seen = 1'b1;
    end
    chk(tag, {31'd0, seen}, 32'd0);
  endtask

  task automatic eoi(input logic [7:0] v);
    @(negedge clk); eoi_valid = 1'b1; eoi_vector = v;
    @(negedge clk); eoi_valid = 1'b0;
  endtask

  initial begin
    logic [31:0] d, lo;
    logic [7:0]  v0;
    bit got;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset contents of every entry and idle output
    #1 chk("R1 msg_valid idle", {31'd0, msg_valid}, 32'd0);
    for (int p = 0; p < 24; p++) begin
      rd(8'(16 + 2 * p), d);     chk("R1 low word", d, 32'h0001_0000);
      rd(8'(16 + 2 * p + 1), d); chk("R1 high word", d, 32'h0);
    end

    // R4 R7: table of edge-mode entries, one message per pulse
    for (int t = 0; t < NV; t++) begin
      lo = {20'd0, TBL[t].lg, TBL[t].dm, TBL[t].vec};
      wr(8'(16 + 2 * TBL[t].pin + 1), {TBL[t].dst, 24'd0});
      wr(8'(16 + 2 * TBL[t].pin), lo);
      rd(8'(16 + 2 * TBL[t].pin), d); chk("R2 table readback", d, lo);
      @(negedge clk); irq_in[TBL[t].pin] = 1'b1;
      wait_msg(20, got);
      chk("R4 message raised", {31'd0, got}, 32'd1);
      chk("R7 vector", {24'd0, msg_vector}, {24'd0, TBL[t].vec});
      chk("R7 dmode", {29'd0, msg_dmode}, {29'd0, TBL[t].dm});
      chk("R7 logical", {31'd0, msg_logical}, {31'd0, TBL[t].lg});
      chk("R7 dest", {24'd0, msg_dest}, {24'd0, TBL[t].dst});
      chk("R7 pin", {27'd0, msg_pin}, {27'd0, TBL[t].pin});
      accept();
      quiet("R4 held input no second msg", 8);
      irq_in[TBL[t].pin] = 1'b0;
    end

    // R2 R3: field masks, read-only status bits, out-of-range indices
    wr(8'h38, 32'hFFFF_FFFF);
    rd(8'h38, d); chk("R3 ro bits ignored / R2 low fields", d, 32'h0001_AFFF);
    wr(8'h39, 32'hFFFF_FFFF);
    rd(8'h39, d); chk("R2 high field", d, 32'hFF00_0000);
    wr(8'h40, 32'h1234_5678);
    wr(8'h0F, 32'h1234_5678);
    rd(8'h40, d); chk("R2 index above range", d, 32'h0);
    rd(8'h0F, d); chk("R2 index below range", d, 32'h0);
    rd(8'h38, d); chk("R2 out-of-range write no effect", d, 32'h0001_AFFF);
    rd(8'h10, d); chk("R2 entry0 unchanged", d, 32'h0000_0031);

    // R5: active-low pin, idle level set while masked
    irq_in[7] = 1'b1;
    repeat (3) @(negedge clk);
    wr(8'h1F, 32'h0500_0000);
    wr(8'h1E, 32'h0000_2077);
    quiet("R5 polarity change no msg", 6);
    @(negedge clk); irq_in[7] = 1'b0;
    wait_msg(20, got);
    chk("R5 falling edge raises", {31'd0, got}, 32'd1);
    chk("R5 vector", {24'd0, msg_vector}, 32'h77);
    accept();
    @(negedge clk); irq_in[7] = 1'b1;
    quiet("R5 rising edge ignored", 8);

    // R6: masked edge discarded, masked level issued on unmask
    wr(8'h14, 32'h0001_0022);
    @(negedge clk); irq_in[2] = 1'b1;
    @(negedge clk); irq_in[2] = 1'b0;
    quiet("R6 masked edge", 8);
    wr(8'h14, 32'h0000_0022);
    quiet("R6 edge discarded after unmask", 8);
    wr(8'h18, 32'h0001_8044);
    @(negedge clk); irq_in[4] = 1'b1;
    quiet("R6 masked level", 8);
    wr(8'h18, 32'h0000_8044);
    wait_msg(20, got);
    chk("R6 level on unmask", {31'd0, got}, 32'd1);
    chk("R6 vector", {24'd0, msg_vector}, 32'h44);
    accept();
    @(negedge clk); irq_in[4] = 1'b0;
    eoi(8'h44);

    // R8 R9: back-pressure with a second request queued
    wr(8'h24, 32'h0000_00A0);
    wr(8'h26, 32'h0000_00B1);
    @(negedge clk); irq_in[10] = 1'b1;
    wait_msg(20, got);
    v0 = msg_vector;
    chk("R8 first valid", {31'd0, got}, 32'd1);
    @(negedge clk); irq_in[11] = 1'b1;
    rd(8'h24, d); chk("R9 status set while waiting", d, 32'h0000_10A0);
    repeat (6) @(negedge clk);
    #1 chk("R8 still valid", {31'd0, msg_valid}, 32'd1);
    chk("R8 vector stable", {24'd0, msg_vector}, {24'd0, v0});
    chk("R8 pin stable", {27'd0, msg_pin}, 32'd10);
    accept();
    rd(8'h24, d); chk("R9 status clear after accept", d, 32'h0000_00A0);
    wait_msg(20, got);
    chk("R8 queued request issued", {31'd0, got}, 32'd1);
    chk("R8 queued vector", {24'd0, msg_vector}, 32'hB1);
    accept();
    irq_in[10] = 1'b0; irq_in[11] = 1'b0;

    // R11: simultaneous edges, lowest pin first
    wr(8'h16, 32'h0000_0033);
    wr(8'h22, 32'h0000_0099);
    @(negedge clk); irq_in[3] = 1'b1; irq_in[9] = 1'b1;
    wait_msg(20, got);
    chk("R11 lowest first", {27'd0, msg_pin}, 32'd3);
    accept();
    wait_msg(20, got);
    chk("R11 then next", {27'd0, msg_pin}, 32'd9);
    chk("R11 next vector", {24'd0, msg_vector}, 32'h99);
    accept();
    irq_in[3] = 1'b0; irq_in[9] = 1'b0;

    // R10: level pin with remote acknowledge
    wr(8'h1B, 32'h0300_0000);
    wr(8'h1A, 32'h0000_8055);
    @(negedge clk); irq_in[5] = 1'b1;
    wait_msg(20, got);
    chk("R10 level raised", {31'd0, got}, 32'd1);
    chk("R10 dest", {24'd0, msg_dest}, 32'h03);
    accept();
    rd(8'h1A, d); chk("R10 remote ack set", d, 32'h0000_C055);
    quiet("R10 no repeat while ack set", 8);
    eoi(8'h54);
    rd(8'h1A, d); chk("R10 wrong eoi keeps ack", d, 32'h0000_C055);
    eoi(8'h55);
    wait_msg(20, got);
    chk("R10 reissue after eoi", {31'd0, got}, 32'd1);
    chk("R10 reissue vector", {24'd0, msg_vector}, 32'h55);
    accept();
    @(negedge clk); irq_in[5] = 1'b0;
    eoi(8'h55);
    rd(8'h1A, d); chk("R10 ack cleared", d, 32'h0000_8055);
    quiet("R10 inactive no msg", 8);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule